// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block sits on the host side of a 12-bit single-channel converter that is started by a falling edge on an active-low convert-start line, reports its conversion with a busy line, and shifts its result out under a clock supplied by the host. When a start request is accepted, the controller lowers convert-start and waits for busy to rise and then fall. It then drives 16 serial-clock pulses at a programmable rate and captures the data line on each falling edge. It presents the 12-bit unsigned result together with a one-cycle valid strobe.

Two modes are supported and chosen per request. In normal mode, convert-start goes back high as soon as busy is seen high, so it is high when the conversion ends and the converter stays awake. In power-down mode, convert-start is held low through the end of the conversion, so the converter sleeps. The next request then first raises the line for one serial half-period to wake it and lowers it again to begin the new conversion.

Top module: `adc_serial_reader`

## Requirements
- R1: After reset, ready is 1, conv_n is 1, sclk is 0, result_valid is 0, and result and frame_err are 0.
- R2: A start pulse while ready is 1 begins a conversion, and ready is 0 from the next cycle until the conversion is finished. A start while ready is 0 is ignored: it causes no further convert-start falling edge and no extra result_valid pulse.
- R3: In normal mode (pd_mode=0 at the request), conv_n returns high after busy is seen high and before busy falls. It stays high after the result.
- R4: In power-down mode (pd_mode=1 at the request), conv_n stays low through the end of the conversion and until the next request. That request first drives conv_n high for one half-period and then low, so no conversion starts while the converter is asleep.
- R5: No sclk rising edge occurs while busy is high. Shifting begins only after busy has risen and then fallen.
- R6: A read frame has exactly 16 sclk pulses. sclk idles low and ends low. Each high phase and each low phase lasts half_div system clocks, where half_div is taken at the request and a value of 0 is treated as 1.
- R7: sdata is sampled at each sclk falling edge, most significant bit first. result is the last 12 of the 16 sampled bits, as an unsigned number.
- R8: frame_err is 1 if any of the first four sampled bits is 1, and 0 otherwise.
- R9: result_valid is a single-cycle pulse, and result and frame_err are updated in the same cycle. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Conversion request, taken when ready is 1 |
| pd_mode | input | 1 | 1 selects power-down mode for this request |
| half_div | input | DIV_W | sclk half-period in system clocks (0 acts as 1) |
| busy | input | 1 | Converter busy indication |
| sdata | input | 1 | Serial data from the converter |
| conv_n | output | 1 | Convert-start, conversion begins on its falling edge |
| sclk | output | 1 | Serial clock to the converter |
| ready | output | 1 | Controller idle and able to accept a request |
| result | output | 12 | Last conversion result |
| result_valid | output | 1 | One-cycle pulse when result is updated |
| frame_err | output | 1 | Leading bits of the last frame were not all zero |

## Verification
A wrong state-machine state shows up within one conversion. Examples are a lost request (ready stuck low and no valid pulse), a second convert-start edge counted by the converter model, or serial clocks while busy is high. An off-by-one in the bit or divider counters shows up in the same frame, as a pulse count other than 16, a wrong high-phase length, or a result shifted by one bit. A wrong mode latch is visible when the conversion completes, through the convert-start level that the converter model records at the busy fall.

// File: rtl/adc_serial_reader.sv
module adc_serial_reader #(
  parameter int DIV_W  = 8,
  parameter int RES_W  = 12,
  parameter int LEAD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pd_mode,
  input  logic [DIV_W-1:0] half_div,
  input  logic             busy,
  input  logic             sdata,
  output logic             conv_n,
  output logic             sclk,
  output logic             ready,
  output logic [RES_W-1:0] result,
  output logic             result_valid,
  output logic             frame_err
);
  localparam int FRAME = RES_W + LEAD_W;
  localparam int CNT_W = $clog2(FRAME + 1);

  typedef enum logic [2:0] {IDLE, WAKE, CONV, BUSYW, SHIFT} state_t;

  state_t             state;
  logic [DIV_W-1:0]   cnt, div_q;
  logic [CNT_W-1:0]   bits;
  logic [FRAME-2:0]   shreg;
  logic               pd_q, sclk_q, cnv_q, valid_q, err_q;
  logic [RES_W-1:0]   res_q;
  logic               tick;

  assign tick         = (cnt == div_q - 1'b1);
  assign ready        = (state == IDLE);
  assign conv_n       = cnv_q;
  assign sclk         = sclk_q;
  assign result       = res_q;
  assign result_valid = valid_q;
  assign frame_err    = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      div_q   <= DIV_W'(1);
      bits    <= '0;
      shreg   <= '0;
      pd_q    <= 1'b0;
      sclk_q  <= 1'b0;
      cnv_q   <= 1'b1;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state)
        IDLE: if (start) begin
          pd_q  <= pd_mode;
          div_q <= (half_div == '0) ? DIV_W'(1) : half_div;
          cnt   <= '0;
          if (!cnv_q) begin
            cnv_q <= 1'b1;
            state <= WAKE;
          end else begin
            cnv_q <= 1'b0;
            state <= CONV;
          end
        end
        WAKE: begin
          if (tick) begin
            cnt   <= '0;
            cnv_q <= 1'b0;
            state <= CONV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CONV: if (busy) begin
          cnv_q <= pd_q ? 1'b0 : 1'b1;
          state <= BUSYW;
        end
        BUSYW: if (!busy) begin
          cnt   <= '0;
          bits  <= '0;
          state <= SHIFT;
        end
        SHIFT: begin
          if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
            if (sclk_q) begin
              shreg <= {shreg[FRAME-3:0], sdata};
              bits  <= bits + 1'b1;
              if (bits == CNT_W'(FRAME - 1)) begin
                res_q   <= {shreg[RES_W-2:0], sdata};
                err_q   <= |shreg[FRAME-2 -: LEAD_W];
                valid_q <= 1'b1;
                state   <= IDLE;
              end
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_serial_reader_chk.sv
module adc_serial_reader_chk #(
  parameter int RES_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             sclk,
  input logic             ready,
  input logic [RES_W-1:0] result,
  input logic             result_valid,
  input logic             frame_err
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);
  // R5
  no_sclk_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !busy);
  // R6
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !sclk);
  // R9
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> ($stable(result) && $stable(frame_err)));
endmodule

bind adc_serial_reader adc_serial_reader_chk #(.RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sclk(sclk),
  .ready(ready), .result(result), .result_valid(result_valid),
  .frame_err(frame_err)
);

// File: tb/tb_adc_serial_reader.sv
module tb_adc_serial_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pd_mode = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic        busy = 1'b0;
  logic        sdata = 1'b1;
  logic        conv_n, sclk, ready, result_valid, frame_err;
  logic [11:0] result;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_word = 16'h0;
  int idx = 0, conv_cnt = 0, fall_cnt = 0, sclk_busy = 0, bad_start = 0;
  int valid_cnt = 0, hi_run = 0, last_hi = 0;
  logic asleep = 1'b0, cnv_at_done = 1'b1;

  always #10 clk = ~clk;

  adc_serial_reader dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pd_mode(pd_mode),
    .half_div(half_div), .busy(busy), .sdata(sdata), .conv_n(conv_n),
    .sclk(sclk), .ready(ready), .result(result),
    .result_valid(result_valid), .frame_err(frame_err)
  );

  // converter model
  initial begin
    forever begin
      @(negedge conv_n);
      if (asleep) bad_start++;
      conv_cnt++;
      @(posedge clk); #1 busy = 1'b1;
      repeat (20) @(posedge clk);
      #1 busy = 1'b0;
      cnv_at_done = conv_n;
      asleep = !conv_n;
      idx = 0;
      sdata = m_word[15];
    end
  end
  always @(posedge conv_n) asleep = 1'b0;
  always @(negedge sclk) begin
    if (busy) sclk_busy++;
    fall_cnt++;
    idx++;
    sdata = (idx < 16) ? m_word[15-idx] : 1'b1;
  end
  always @(negedge clk) begin
    if (result_valid) valid_cnt++;
    if (sclk) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input bit mode, input int div, input logic [15:0] word);
    int ediv;
    ediv = (div == 0) ? 1 : div;
    m_word = word;
    fall_cnt = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    start = 1'b1; pd_mode = mode; half_div = 8'(div);
    @(negedge clk);
    start = 1'b0;
    chk(!ready, "R2 ready low after accept", ready, 0);
    for (int i = 0; i < 5000; i++) begin
      if (result_valid) break;
      @(negedge clk);
    end
    chk(result_valid, "R9 valid seen", result_valid, 1);
    chk(result == word[11:0], "R7 result", result, word[11:0]);
    chk(frame_err == (|word[15:12]), "R8 frame_err", frame_err, |word[15:12]);
    chk(fall_cnt == 16, "R6 pulse count", fall_cnt, 16);
    chk(last_hi == ediv, "R6 high phase", last_hi, ediv);
    chk(sclk_busy == 0, "R5 sclk while busy", sclk_busy, 0);
    if (mode) begin
      chk(conv_n == 1'b0, "R4 conv_n held low", conv_n, 0);
      chk(asleep, "R4 converter asleep", asleep, 1);
    end else begin
      chk(conv_n == 1'b1, "R3 conv_n high", conv_n, 1);
      chk(cnv_at_done == 1'b1, "R3 conv_n high at busy fall", cnv_at_done, 1);
    end
    @(negedge clk);
    chk(!result_valid, "R9 single pulse", result_valid, 0);
    chk(ready && !sclk, "R2 R6 idle after frame", {ready, sclk}, 2'b10);
  endtask

  // {pd_mode, half_div[3:0], word[15:0]}
  localparam logic [20:0] VEC [6] = '{
    {1'b0, 4'd1, 16'h0ABC},
    {1'b0, 4'd3, 16'h0FFF},
    {1'b1, 4'd2, 16'h0000},
    {1'b1, 4'd1, 16'h0801},
    {1'b0, 4'd0, 16'h5123},
    {1'b0, 4'd4, 16'h8FFE}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(ready && conv_n && !sclk && !result_valid && result == 0 && !frame_err,
        "R1 reset state", {ready, conv_n, sclk, result_valid}, 4'b1100);
    rst_n = 1'b1;
    for (int v = 0; v < 6; v++)
      run_vec(VEC[v][20], int'(VEC[v][19:16]), VEC[v][15:0]);
    chk(bad_start == 0, "R4 no start while asleep", bad_start, 0);

    // R2: extra start during an active conversion is ignored
    begin
      int c0, v0;
      logic [11:0] r0;
      c0 = conv_cnt; v0 = valid_cnt; r0 = result;
      m_word = 16'h0321; fall_cnt = 0;
      @(negedge clk);
      start = 1'b1; pd_mode = 1'b0; half_div = 8'd2;
      @(negedge clk); start = 1'b0;
      repeat (8) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(result == r0, "R9 result held during conversion", result, r0);
      repeat (300) @(negedge clk);
      chk(conv_cnt == c0 + 1, "R2 ignored start conversions", conv_cnt, c0 + 1);
      chk(valid_cnt == v0 + 1, "R2 ignored start valids", valid_cnt, v0 + 1);
      chk(result == 12'h321, "R7 result after ignored start", result, 12'h321);
      repeat (20) @(negedge clk);
      chk(result == 12'h321 && !frame_err, "R9 result held while idle", result, 12'h321);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule